// File: doc/BRIEF.md
# Horizontal-Blank Paced Video Memory Copy Engine

This block copies data from a 16-bit system address space into an 8 KB video memory window at 0x8000-0x9FFF. It always moves whole chunks of 16 consecutive bytes. Software sets it up through five byte-wide registers on a small register bus. Two registers hold the source pointer and two hold the destination pointer. The fifth register takes the chunk count and the transfer mode, and reads back as the transfer status.

There are two modes. A general transfer moves every chunk back to back as soon as it is started. A paced transfer waits for a one-cycle horizontal-blank pulse before each chunk, so that video memory is only touched while the display is not reading it. A paced transfer can be shortened or cancelled while it runs. Memory access goes through a single synchronous byte port. A read is requested in one cycle, and the returned byte is written to the destination in the next cycle.

Top module: `vdma_engine`

## Requirements
- R1: The source byte address is {src_hi, src_lo[7:4], i}, where i (0..15) is the byte index within the chunk. Bits 3:0 of src_lo have no effect on the address.
- R2: The destination byte address is 0x8000 | dst_hi[4:0]<<8 | dst_lo[7:4]<<4 | i. Every write therefore stays in 0x8000-0x9FFF, and the chunk after the one at 0x9FF0 lands at 0x8000.
- R3: A chunk moves 16 consecutive bytes. Each byte takes two cycles: one cycle with mem_re high, then the next cycle with mem_we high, carrying the byte that the memory returned after the read. mem_re and mem_we are never high together.
- R4: After each chunk, the source pair (index 0 = high, index 1 = low) reads back the address just past the chunk. The destination pair (index 2, index 3) reads back the chunk's formed destination address plus 16 (a chunk at 0x9FF0 leaves 0xA0, 0x00).
- R5: The length register (index 4) is decremented after every chunk. The transfer stops when bit 7 becomes set, so a programmed count n moves n+1 chunks and leaves 0xFF.
- R6: A write to index 4 while idle loads bits 6:0 as the count and starts a transfer. With bit 7 clear, all chunks run back to back, in (n+1)*32 cycles. A write to index 4 during a general transfer has no effect.
- R7: With bit 7 set, no memory access occurs until a horizontal-blank pulse. Each pulse that arrives while the engine waits starts exactly one chunk in the next cycle.
- R8: A horizontal-blank pulse has no effect while the engine is idle, during a general transfer, or while a chunk is in progress.
- R9: A write to index 4 with bit 7 clear during a paced transfer stops it at once and sets the length register to 0xFF. Later pulses move no data.
- R10: A write to index 4 with bit 7 set during a paced transfer replaces the remaining count with bits 6:0 and keeps the transfer running.
- R11: busy rises in the cycle after the starting write and stays high through the final write cycle of the last chunk, or until a cancel.
- R12: Indexes 0-4 read back as listed above, and indexes 5-7 read 0x00. Writes to indexes 0-3 have no effect while busy. After reset, all registers read 0x00 except the length register, which reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for writes and read-back |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read-back of the indexed register (combinational) |
| hblank | input | 1 | One-cycle horizontal-blank pulse |
| busy | output | 1 | Transfer in progress |
| mem_re | output | 1 | Memory byte read request |
| mem_we | output | 1 | Memory byte write request |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_re |

## Verification
The hardest situations to reach are the ones inside a paced transfer: a blank pulse arriving in the middle of a chunk, and a count rewrite or a cancel landing between two pulses. The stimulus starts a paced transfer and fires a pulse. It then counts cycles from that pulse to place a second pulse partway into the 32-cycle chunk, and to place the register write in the waiting gap after the chunk. Byte-write counts and the destination contents then show whether each pulse moved exactly one chunk. A destination byte just past the cancelled point is checked to confirm it stayed untouched.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
    localparam int REG_W     = 8;
    localparam int ADDR_W    = 16;
    localparam int RIX_W     = 3;
    localparam int WIN_SEL_W = 3;
    localparam logic [WIN_SEL_W-1:0] WIN_SEL = 3'b100;
    localparam int DHI_W     = ADDR_W - WIN_SEL_W - REG_W;

    localparam logic [RIX_W-1:0] RIX_SRC_HI = 3'd0;
    localparam logic [RIX_W-1:0] RIX_SRC_LO = 3'd1;
    localparam logic [RIX_W-1:0] RIX_DST_HI = 3'd2;
    localparam logic [RIX_W-1:0] RIX_DST_LO = 3'd3;
    localparam logic [RIX_W-1:0] RIX_LEN    = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } vdma_state_e;
endpackage

// File: rtl/vdma_addr.sv
module vdma_addr
    import vdma_pkg::*;
#(
    parameter int CHUNK_LOG2 = 4
) (
    input  logic [REG_W-1:0]            src_hi,
    input  logic [REG_W-CHUNK_LOG2-1:0] src_lo_keep,
    input  logic [DHI_W-1:0]            dst_hi_keep,
    input  logic [REG_W-CHUNK_LOG2-1:0] dst_lo_keep,
    input  logic [CHUNK_LOG2-1:0]       idx,
    output logic [ADDR_W-1:0]           rd_addr,
    output logic [ADDR_W-1:0]           wr_addr,
    output logic [REG_W-1:0]            nsrc_hi,
    output logic [REG_W-1:0]            nsrc_lo,
    output logic [REG_W-1:0]            ndst_hi,
    output logic [REG_W-1:0]            ndst_lo
);
    localparam int BLK_W = ADDR_W - CHUNK_LOG2;

    logic [BLK_W-1:0]  sblk, dblk, sblk_n, dblk_n;
    logic [ADDR_W-1:0] snext, dnext;

    // Chunk-aligned block numbers; the byte index fills the low bits.
    assign sblk    = {src_hi, src_lo_keep};
    assign dblk    = {WIN_SEL, dst_hi_keep, dst_lo_keep};
    assign rd_addr = {sblk, idx};
    assign wr_addr = {dblk, idx};

    assign sblk_n  = sblk + 1'b1;
    assign dblk_n  = dblk + 1'b1;
    assign snext   = {sblk_n, {CHUNK_LOG2{1'b0}}};
    assign dnext   = {dblk_n, {CHUNK_LOG2{1'b0}}};

    assign nsrc_hi = snext[ADDR_W-1:REG_W];
    assign nsrc_lo = snext[REG_W-1:0];
    assign ndst_hi = dnext[ADDR_W-1:REG_W];
    assign ndst_lo = dnext[REG_W-1:0];
endmodule

// File: rtl/vdma_rdmux.sv
module vdma_rdmux
    import vdma_pkg::*;
(
    input  logic [RIX_W-1:0] sel,
    input  logic [REG_W-1:0] src_hi,
    input  logic [REG_W-1:0] src_lo,
    input  logic [REG_W-1:0] dst_hi,
    input  logic [REG_W-1:0] dst_lo,
    input  logic [REG_W-1:0] len,
    output logic [REG_W-1:0] rdata
);
    always_comb begin
        case (sel)
            RIX_SRC_HI: rdata = src_hi;
            RIX_SRC_LO: rdata = src_lo;
            RIX_DST_HI: rdata = dst_hi;
            RIX_DST_LO: rdata = dst_lo;
            RIX_LEN:    rdata = len;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/vdma_engine.sv
module vdma_engine
    import vdma_pkg::*;
#(
    parameter int CHUNK_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [RIX_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              hblank,
    output logic              busy,
    output logic              mem_re,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [REG_W-1:0]  mem_wdata,
    input  logic [REG_W-1:0]  mem_rdata
);
    localparam int IDX_W   = CHUNK_LOG2;
    localparam int LO_KEEP = REG_W - CHUNK_LOG2;

    typedef struct packed {
        vdma_state_e      st;
        logic             paced;
        logic [IDX_W-1:0] idx;
        logic [REG_W-1:0] src_hi;
        logic [REG_W-1:0] src_lo;
        logic [REG_W-1:0] dst_hi;
        logic [REG_W-1:0] dst_lo;
        logic [REG_W-1:0] len;
    } regs_t;

    regs_t q, d;

    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [REG_W-1:0]  nsrc_hi, nsrc_lo, ndst_hi, ndst_lo;
    logic [REG_W-1:0]  len_cur;

    vdma_addr #(.CHUNK_LOG2(CHUNK_LOG2)) u_addr (
        .src_hi      (q.src_hi),
        .src_lo_keep (q.src_lo[REG_W-1:CHUNK_LOG2]),
        .dst_hi_keep (q.dst_hi[DHI_W-1:0]),
        .dst_lo_keep (q.dst_lo[REG_W-1:CHUNK_LOG2]),
        .idx         (q.idx),
        .rd_addr     (rd_addr),
        .wr_addr     (wr_addr),
        .nsrc_hi     (nsrc_hi),
        .nsrc_lo     (nsrc_lo),
        .ndst_hi     (ndst_hi),
        .ndst_lo     (ndst_lo)
    );

    vdma_rdmux u_rdmux (
        .sel    (reg_addr),
        .src_hi (q.src_hi),
        .src_lo (q.src_lo),
        .dst_hi (q.dst_hi),
        .dst_lo (q.dst_lo),
        .len    (q.len),
        .rdata  (reg_rdata)
    );

    always_comb begin
        d        = q;
        mem_re   = 1'b0;
        mem_we   = 1'b0;
        mem_addr = rd_addr;

        // Sequencer: wait for a pulse, then read/write pairs per byte.
        case (q.st)
            ST_WAIT: begin
                if (hblank) d.st = ST_RD;
            end
            ST_RD: begin
                mem_re = 1'b1;
                d.st   = ST_WR;
            end
            ST_WR: begin
                mem_we   = 1'b1;
                mem_addr = wr_addr;
                d.idx    = q.idx + 1'b1;
                d.st     = ST_RD;
                if (q.idx == {IDX_W{1'b1}}) begin
                    d.src_hi = nsrc_hi;
                    d.src_lo = nsrc_lo;
                    d.dst_hi = ndst_hi;
                    d.dst_lo = ndst_lo;
                    d.len    = q.len - 1'b1;
                    if (d.len[REG_W-1])  d.st = ST_IDLE;
                    else if (q.paced)    d.st = ST_WAIT;
                end
            end
            default: ;
        endcase

        // Register bus: address pointers locked while a transfer runs.
        if (reg_we) begin
            case (reg_addr)
                RIX_SRC_HI: if (q.st == ST_IDLE) d.src_hi = reg_wdata;
                RIX_SRC_LO: if (q.st == ST_IDLE) d.src_lo = reg_wdata;
                RIX_DST_HI: if (q.st == ST_IDLE) d.dst_hi = reg_wdata;
                RIX_DST_LO: if (q.st == ST_IDLE) d.dst_lo = reg_wdata;
                RIX_LEN: begin
                    if (q.st == ST_IDLE) begin
                        d.len   = {1'b0, reg_wdata[REG_W-2:0]};
                        d.paced = reg_wdata[REG_W-1];
                        d.idx   = '0;
                        d.st    = reg_wdata[REG_W-1] ? ST_WAIT : ST_RD;
                    end else if (q.paced) begin
                        if (reg_wdata[REG_W-1]) begin
                            d.len = {1'b0, reg_wdata[REG_W-2:0]};
                            if (d.st == ST_IDLE) d.st = ST_WAIT;
                        end else begin
                            d.len = '1;
                            d.st  = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, paced: 1'b0, idx: '0, src_hi: '0, src_lo: '0,
                   dst_hi: '0, dst_lo: '0, len: '1};
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st != ST_IDLE);
    assign mem_wdata = mem_rdata;
    assign len_cur   = q.len;
endmodule

// File: rtl/vdma_chk.sv
module vdma_chk
    import vdma_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mem_re,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [REG_W-1:0]  len_cur
);
    // R3: a byte is read and written in separate cycles
    a_r3_no_dual_op: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    // R3: every write is preceded by the read that fetched its byte
    a_r3_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(mem_re));

    // R2: writes never leave the video window
    a_r2_dst_window: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[ADDR_W-1:ADDR_W-WIN_SEL_W] == WIN_SEL));

    // R11: the memory port is quiet while not busy
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_re && !mem_we));

    // R5 / R9: every ending, normal or cancelled, leaves the 0xFF status
    a_r5_end_status: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (len_cur == 8'hFF));
endmodule

bind vdma_engine vdma_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .mem_re   (mem_re),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .len_cur  (len_cur)
);

// File: tb/sim_vdma_engine.sv
module sim_vdma_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        hblank = 1'b0;
    logic        busy, mem_re, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    int tests = 0;
    int fails = 0;
    int wr_cnt = 0;

    logic [7:0] mem [0:8191];

    always #5 clk = ~clk;

    vdma_engine u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hblank(hblank),
        .busy(busy), .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic int mix(input logic [15:0] a);
        return {19'd0, a[15], a[11:0]};
    endfunction

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'hA5;
    endfunction

    // Synchronous byte memory: read data appears the cycle after mem_re.
    always @(posedge clk) begin
        if (mem_re) mem_rdata = mem[mix(mem_addr)];
        if (mem_we) begin
            mem[mix(mem_addr)] = mem_wdata;
            wr_cnt = wr_cnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic pulse();
        @(negedge clk);
        hblank = 1'b1;
        @(negedge clk);
        hblank = 1'b0;
    endtask

    task automatic setup(input logic [7:0] sh, sl, dh, dl);
        wr(3'd0, sh); wr(3'd1, sl); wr(3'd2, dh); wr(3'd3, dl);
    endtask

    // Compare destination contents against the source pattern.
    task automatic chk_copy(input string tag, input logic [15:0] src,
                            input logic [15:0] dst0, input int nbytes);
        int bad = 0;
        logic [7:0] a_v = '0, e_v = '0;
        for (int j = 0; j < nbytes; j++) begin
            logic [15:0] s, dd;
            s  = src + 16'(j);
            dd = 16'h8000 | ((dst0 + 16'(j)) & 16'h1FFF);
            if (mem[mix(dd)] !== pat(s)) begin
                if (bad == 0) begin a_v = mem[mix(dd)]; e_v = pat(s); end
                bad++;
            end
        end
        chk(tag, {24'd0, a_v}, {24'd0, e_v});
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_up();
    end

    initial begin : main
        logic [7:0] v;
        int n, w0;
        for (int i = 0; i < 4096; i++) begin
            mem[i] = pat(16'(i));
            mem[4096 + i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        rd(3'd4, v); chk("R12 reset len", {24'd0, v}, 32'hFF);
        rd(3'd0, v); chk("R12 reset src_hi", {24'd0, v}, 32'h00);
        chk("R11 reset busy", {31'd0, busy}, 32'd0);

        // R12: read-back and unused indexes
        wr(3'd1, 8'h2F);
        rd(3'd1, v); chk("R12 readback src_lo", {24'd0, v}, 32'h2F);
        rd(3'd6, v); chk("R12 unused index", {24'd0, v}, 32'h00);

        // R8: pulse while idle
        w0 = wr_cnt;
        pulse(); repeat (5) @(negedge clk);
        chk("R8 idle pulse writes", wr_cnt - w0, 0);
        chk("R8 idle pulse busy", {31'd0, busy}, 32'd0);

        // R1 R2 R3 R4 R6 R11: single general chunk, low nibble of src_lo ignored
        setup(8'h01, 8'h23, 8'hE5, 8'h3C);
        w0 = wr_cnt;
        wr(3'd4, 8'h00);
        count_busy(n);
        chk("R11 busy cycles n=0", n, 32);
        chk("R3 byte writes n=0", wr_cnt - w0, 16);
        chk_copy("R1 R2 copy n=0", 16'h0120, 16'h8530, 16);
        rd(3'd0, v); chk("R4 src_hi after", {24'd0, v}, 32'h01);
        rd(3'd1, v); chk("R4 src_lo after", {24'd0, v}, 32'h30);
        rd(3'd2, v); chk("R4 dst_hi after", {24'd0, v}, 32'h85);
        rd(3'd3, v); chk("R4 dst_lo after", {24'd0, v}, 32'h40);
        rd(3'd4, v); chk("R5 len after n=0", {24'd0, v}, 32'hFF);

        // R2 R4 R5: two chunks wrapping from 0x9FF0 to 0x8000
        setup(8'h02, 8'h00, 8'h1F, 8'hF0);
        wr(3'd4, 8'h01);
        count_busy(n);
        chk("R11 busy cycles n=1", n, 64);
        chk_copy("R2 wrap copy", 16'h0200, 16'h9FF0, 32);
        rd(3'd2, v); chk("R4 dst_hi after wrap", {24'd0, v}, 32'h80);
        rd(3'd3, v); chk("R4 dst_lo after wrap", {24'd0, v}, 32'h10);

        // R5 R6 R8: 128 chunks, with pulses and a count write mid-way
        setup(8'h04, 8'h00, 8'h08, 8'h00);
        w0 = wr_cnt;
        wr(3'd4, 8'h7F);
        fork
            count_busy(n);
            begin
                repeat (100) @(negedge clk);
                pulse();
                wr(3'd4, 8'h85);
                repeat (300) @(negedge clk);
                wr(3'd4, 8'h03);
            end
        join
        chk("R6 busy cycles n=127", n, 4096);
        chk("R8 byte writes n=127", wr_cnt - w0, 2048);
        chk_copy("R5 copy n=127", 16'h0400, 16'h8800, 2048);
        rd(3'd0, v); chk("R4 src_hi n=127", {24'd0, v}, 32'h0C);
        rd(3'd2, v); chk("R4 dst_hi n=127", {24'd0, v}, 32'h90);

        // R7 R8 R10 R12: paced transfer
        setup(8'h0C, 8'h00, 8'h10, 8'h00);
        w0 = wr_cnt;
        wr(3'd4, 8'h82);
        repeat (50) @(negedge clk);
        chk("R7 no writes before pulse", wr_cnt - w0, 0);
        chk("R11 busy while waiting", {31'd0, busy}, 32'd1);
        pulse();
        repeat (8) @(negedge clk);
        pulse();
        repeat (60) @(negedge clk);
        chk("R8 mid-chunk pulse ignored", wr_cnt - w0, 16);
        rd(3'd4, v); chk("R7 len after one chunk", {24'd0, v}, 32'h01);
        wr(3'd0, 8'h77);
        rd(3'd0, v); chk("R12 src write ignored while busy", {24'd0, v}, 32'h0C);
        rd(3'd1, v); chk("R4 paced src_lo", {24'd0, v}, 32'h10);
        wr(3'd4, 8'h80);
        rd(3'd4, v); chk("R10 rewritten count", {24'd0, v}, 32'h00);
        chk("R10 still busy", {31'd0, busy}, 32'd1);
        pulse();
        repeat (40) @(negedge clk);
        chk("R10 writes after rewrite", wr_cnt - w0, 32);
        chk("R10 done busy", {31'd0, busy}, 32'd0);
        rd(3'd4, v); chk("R5 paced end len", {24'd0, v}, 32'hFF);
        chk_copy("R7 paced copy", 16'h0C00, 16'h9000, 32);

        // R9: cancel between pulses
        setup(8'h0D, 8'h00, 8'h14, 8'h00);
        w0 = wr_cnt;
        wr(3'd4, 8'h85);
        pulse();
        repeat (40) @(negedge clk);
        rd(3'd4, v); chk("R9 len before cancel", {24'd0, v}, 32'h04);
        wr(3'd4, 8'h00);
        rd(3'd4, v); chk("R9 len after cancel", {24'd0, v}, 32'hFF);
        chk("R9 busy after cancel", {31'd0, busy}, 32'd0);
        pulse();
        repeat (40) @(negedge clk);
        chk("R9 no writes after cancel", wr_cnt - w0, 16);
        chk("R9 next chunk untouched", {24'd0, mem[mix(16'h9410)]}, 32'h00);
        chk_copy("R9 first chunk copied", 16'h0D00, 16'h9400, 16);

        finish_up();
    end
endmodule